// File: doc/BRIEF.md
# Cascadable Delay-Select Latch Controller

This block holds the tap-select code of a programmable delay element and turns it into an effective delay setting. A seven-bit select bus and one cascade bit pass through a level-controlled capture stage. The hold input freezes the captured code, and two override inputs pin the stage at its shortest or its longest setting. The captured code is binary weighted in quarter-gate units. The two lowest bits add a quarter and a half of a gate, and the upper bits add 1, 2, 4, 8 and 16 gates. The resulting delay is reported as an integer count of quarter gates.

The delay element itself is modelled as a clocked shift line, and the computed delay picks its tap. A mute input forces the data output low. The captured cascade bit drives a complementary output pair, so stages can be chained with no external gating. In a chain, stage 1's cascade output drives its own maximum override, and its inverted cascade output drives stage 2's minimum override. With that wiring, one shared select bus plus one extra bit per stage spans the combined range.

Top module: `delay_sel_ctrl`

## Requirements
- R1: After reset, `delay_o` is 0, `casc_o` is 0, `casc_n_o` is 1 and `sig_o` is 0.
- R2: With `hold_i` low and no override, one clock edge copies `sel_i` into the capture stage. `delay_o` then equals `sel_i` read as an unsigned number. Bit k has weight 2^k quarter gates (bit 0 = 0.25 gate, bit 6 = 16 gates).
- R3: With `hold_i` high and no override, changes on `sel_i` and `casc_i` have no effect on `delay_o` or `casc_o`.
- R4: `casc_o` equals the captured cascade bit, and `casc_n_o` is its complement.
- R5: While `force_min_i` is high, every captured bit is cleared, so `delay_o` is 0 and `casc_o` is 0, whatever the select bus does. After release with `hold_i` high, the cleared code stays until `hold_i` goes low.
- R6: While `force_max_i` is high (and `force_min_i` is low), the two lowest captured bits are cleared, all other bits including the cascade bit are set, and one extra gate is added. `delay_o` is then 128 and `casc_o` is 1. After release with `hold_i` high, the extra gate drops out and `delay_o` is 124.
- R7: When both overrides are high, the minimum override wins: `delay_o` is 0 and `casc_o` is 0.
- R8: An all-ones select code with no override gives 127, one quarter gate below the forced maximum.
- R9: While `mute_i` is high, `sig_o` is 0.
- R10: With `mute_i` low, a single-cycle pulse on `sig_i` first appears on `sig_o` after `delay_o + 1` rising clock edges.
- R11: Two stages wired as a chain, swept with an 8-bit count (low seven bits on the shared bus, top bit on stage 1's `casc_i`), give a summed delay equal to the count. The sum therefore rises monotonically from 0 to 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 7 | Delay select bus, bit k weighs 2^k quarter gates |
| casc_i | input | 1 | Cascade control bit, captured with the bus |
| hold_i | input | 1 | Low: capture stage follows the bus; high: capture stage holds |
| force_min_i | input | 1 | Clears all captured bits (minimum delay) |
| force_max_i | input | 1 | Forces the maximum pattern and adds one gate |
| mute_i | input | 1 | High forces `sig_o` low |
| sig_i | input | 1 | Data input to the delay line |
| delay_o | output | 8 | Effective delay in quarter-gate units |
| casc_o | output | 1 | Captured cascade bit |
| casc_n_o | output | 1 | Complement of `casc_o` |
| sig_o | output | 1 | Delayed data output |

## Verification
The bench walks a one-hot code across the bus. A design with a swapped or misweighted bit would report the wrong power of two. It drives the bus while the stage holds and while the minimum override is active, to catch a capture that leaks through. It checks the override boundaries: 127 against 128, the drop to 124 once the maximum override is released, and the case where both overrides are asserted. A design with the priority reversed would report 128 there. Finally, it measures pulse latency at taps 0, 5, 127 and 128, and sweeps a two-stage chain through all 256 counts. An off-by-one in the tap, or a missing extra gate, would break either the exact latency or the strict rise of the chained sum at the 127-to-128 step.

// File: rtl/delay_sel_pkg.sv
package delay_sel_pkg;
  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_MIN  = 2'd1,
    OVR_MAX  = 2'd2
  } ovr_e;

  // minimum override has priority
  function automatic ovr_e ovr_decode(input logic mn, input logic mx);
    if (mn)      return OVR_MIN;
    else if (mx) return OVR_MAX;
    else         return OVR_NONE;
  endfunction
endpackage

// File: rtl/delay_latch_bank.sv
module delay_latch_bank
  import delay_sel_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int FRAC_BITS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  ovr_e            ovr_i,
  input  logic [ADDR_W:0] bus_i,
  output logic [ADDR_W:0] lat_o,
  output logic            max_o
);
  for (genvar k = 0; k <= ADDR_W; k++) begin : g_bit
    localparam logic SET_V = (k >= FRAC_BITS);
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bit_q <= 1'b0;
      end else begin
        case (ovr_i)
          OVR_MIN: bit_q <= 1'b0;
          OVR_MAX: bit_q <= SET_V;
          default: if (!hold_i) bit_q <= bus_i[k];
        endcase
      end
    end
    assign lat_o[k] = bit_q;
  end

  logic max_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) max_q <= 1'b0;
    else         max_q <= (ovr_i == OVR_MAX);
  end
  assign max_o = max_q;
endmodule

// File: rtl/delay_calc.sv
module delay_calc #(
  parameter int ADDR_W    = 7,
  parameter int FRAC_BITS = 2,
  localparam int DLY_W    = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0] code_i,
  input  logic              max_i,
  output logic [DLY_W-1:0]  delay_o
);
  localparam logic [DLY_W-1:0] EXTRA = DLY_W'(1 << FRAC_BITS);
  always_comb begin
    delay_o = DLY_W'(code_i);
    if (max_i) delay_o = delay_o + EXTRA;
  end
endmodule

// File: rtl/tap_line.sv
module tap_line #(
  parameter int DEPTH = 129,
  parameter int TAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_i,
  input  logic [TAP_W-1:0] tap_i,
  input  logic             mute_i,
  output logic             sig_o
);
  logic [DEPTH-1:0] sr_q;
  logic             tapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[DEPTH-2:0], sig_i};
  end

  always_comb begin
    tapped = sr_q[DEPTH-1];
    for (int i = 0; i < DEPTH; i++)
      if (int'(tap_i) == i) tapped = sr_q[i];
  end

  assign sig_o = mute_i ? 1'b0 : tapped;
endmodule

// File: rtl/delay_sel_ctrl.sv
module delay_sel_ctrl
  import delay_sel_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int FRAC_BITS = 2,
  localparam int DLY_W    = ADDR_W + 1,
  localparam int DEPTH    = (1 << ADDR_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] sel_i,
  input  logic              casc_i,
  input  logic              hold_i,
  input  logic              force_min_i,
  input  logic              force_max_i,
  input  logic              mute_i,
  input  logic              sig_i,
  output logic [DLY_W-1:0]  delay_o,
  output logic              casc_o,
  output logic              casc_n_o,
  output logic              sig_o
);
  ovr_e            ovr;
  logic [ADDR_W:0] lat;
  logic            max_q;

  assign ovr = ovr_decode(force_min_i, force_max_i);

  delay_latch_bank #(.ADDR_W(ADDR_W), .FRAC_BITS(FRAC_BITS)) u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold_i),
    .ovr_i  (ovr),
    .bus_i  ({casc_i, sel_i}),
    .lat_o  (lat),
    .max_o  (max_q)
  );

  delay_calc #(.ADDR_W(ADDR_W), .FRAC_BITS(FRAC_BITS)) u_calc (
    .code_i  (lat[ADDR_W-1:0]),
    .max_i   (max_q),
    .delay_o (delay_o)
  );

  tap_line #(.DEPTH(DEPTH), .TAP_W(DLY_W)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig_i),
    .tap_i  (delay_o),
    .mute_i (mute_i),
    .sig_o  (sig_o)
  );

  assign casc_o   = lat[ADDR_W];
  assign casc_n_o = ~lat[ADDR_W];
endmodule

// File: rtl/delay_sel_chk.sv
module delay_sel_chk #(
  parameter int ADDR_W = 7,
  localparam int DLY_W = ADDR_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] sel_i,
  input logic              casc_i,
  input logic              hold_i,
  input logic              force_min_i,
  input logic              force_max_i,
  input logic              mute_i,
  input logic [DLY_W-1:0]  delay_o,
  input logic              casc_o,
  input logic              sig_o,
  input logic              max_q
);
  localparam logic [DLY_W-1:0] MAX_Q = DLY_W'(1 << ADDR_W);

  assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !force_min_i && !force_max_i) |=>
      (delay_o == DLY_W'($past(sel_i)) && casc_o == $past(casc_i)));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !force_min_i && !force_max_i && !max_q) |=>
      ($stable(delay_o) && $stable(casc_o)));

  assert_force_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_min_i |=> (delay_o == '0 && !casc_o));

  assert_force_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_max_i && !force_min_i) |=> (delay_o == MAX_Q && casc_o));

  assert_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_o <= MAX_Q);

  assert_mute_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_i |-> !sig_o);
endmodule

bind delay_sel_ctrl delay_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .casc_i      (casc_i),
  .hold_i      (hold_i),
  .force_min_i (force_min_i),
  .force_max_i (force_max_i),
  .mute_i      (mute_i),
  .delay_o     (delay_o),
  .casc_o      (casc_o),
  .sig_o       (sig_o),
  .max_q       (max_q)
);

// File: tb/sim_delay_sel_ctrl.sv
`timescale 1ns/1ps
module sim_delay_sel_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] sel = '0;
  logic       casc = 1'b0, hold = 1'b0, fmin = 1'b0, fmax = 1'b0, mute = 1'b0, sig = 1'b0;
  logic [7:0] dly;
  logic       co, con, so;

  logic [6:0] c_sel = '0;
  logic       c_top = 1'b0;
  logic [7:0] d1, d2;
  logic       s1_co, s1_con, s1_so, s2_co, s2_con, s2_so;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  delay_sel_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .casc_i(casc), .hold_i(hold),
    .force_min_i(fmin), .force_max_i(fmax), .mute_i(mute), .sig_i(sig),
    .delay_o(dly), .casc_o(co), .casc_n_o(con), .sig_o(so)
  );

  // chain: stage 1 max from own cascade, stage 2 min from stage 1 cascade-bar
  delay_sel_ctrl u_s1 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(c_sel), .casc_i(c_top), .hold_i(1'b0),
    .force_min_i(1'b0), .force_max_i(s1_co), .mute_i(1'b0), .sig_i(1'b0),
    .delay_o(d1), .casc_o(s1_co), .casc_n_o(s1_con), .sig_o(s1_so)
  );
  delay_sel_ctrl u_s2 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(c_sel), .casc_i(1'b0), .hold_i(1'b0),
    .force_min_i(s1_con), .force_max_i(1'b0), .mute_i(1'b0), .sig_i(s1_so),
    .delay_o(d2), .casc_o(s2_co), .casc_n_o(s2_con), .sig_o(s2_so)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic latency(input string req, input int exp_d);
    int k;
    sig = 1'b0;
    step(140);
    sig = 1'b1;
    step();
    sig = 1'b0;
    k = 1;
    while (!so && k < 300) begin
      step();
      k++;
    end
    chk(req, k, exp_d + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int prev;
    step(3);
    rst_ni = 1'b1;
    step();
    // R1 reset state
    chk("R1 delay", dly, 0);
    chk("R1 casc", co, 0);
    chk("R1 casc_n", con, 1);
    chk("R1 sig", so, 0);

    // R2 pass-through and bit weights
    sel = 7'h25; step(); chk("R2 0x25", dly, 37);
    sel = 7'h5A; step(); chk("R2 0x5A", dly, 90);
    for (int b = 0; b < 7; b++) begin
      sel = 7'(1 << b); step();
      chk("R2 weight", dly, 1 << b);
    end
    // R8 all ones
    sel = 7'h7F; step(); chk("R8 all ones", dly, 127);
    chk("R8 casc", co, 0);

    // R4 cascade pair
    casc = 1'b1; step();
    chk("R4 casc high", co, 1);
    chk("R4 casc_n low", con, 0);
    casc = 1'b0; step();
    chk("R4 casc low", co, 0);
    chk("R4 casc_n high", con, 1);

    // R3 hold
    sel = 7'd10; step();
    hold = 1'b1; sel = 7'd99; casc = 1'b1; step(2);
    chk("R3 held delay", dly, 10);
    chk("R3 held casc", co, 0);
    casc = 1'b0;

    // R5 minimum override
    hold = 1'b0; sel = 7'd50; step();
    fmin = 1'b1; sel = 7'd77; casc = 1'b1; step();
    chk("R5 min delay", dly, 0);
    chk("R5 min casc", co, 0);
    sel = 7'd33; step();
    chk("R5 bus ignored", dly, 0);
    hold = 1'b1; fmin = 1'b0; casc = 1'b0; step();
    chk("R5 stays cleared", dly, 0);
    hold = 1'b0; step();
    chk("R5 resume", dly, 33);

    // R6 maximum override
    hold = 1'b1; fmax = 1'b1; step();
    chk("R6 max delay", dly, 128);
    chk("R6 max casc", co, 1);
    fmax = 1'b0; step();
    chk("R6 released", dly, 124);
    chk("R6 released casc", co, 1);

    // R7 both overrides
    fmax = 1'b1; fmin = 1'b1; step();
    chk("R7 min wins delay", dly, 0);
    chk("R7 min wins casc", co, 0);
    fmax = 1'b0; fmin = 1'b0; hold = 1'b0;

    // R10 latency
    sel = 7'd0;  step(); latency("R10 tap 0", 0);
    sel = 7'd5;  step(); latency("R10 tap 5", 5);
    sel = 7'h7F; step(); latency("R10 tap 127", 127);
    fmax = 1'b1; step(); latency("R10 tap 128", 128);
    fmax = 1'b0; fmin = 1'b1; step(); fmin = 1'b0;

    // R9 mute
    sel = 7'd0; sig = 1'b1; step(3);
    chk("R9 unmuted", so, 1);
    mute = 1'b1; #1;
    chk("R9 muted", so, 0);
    step(2);
    chk("R9 muted later", so, 0);
    mute = 1'b0; #1;
    chk("R9 unmuted again", so, 1);
    sig = 1'b0;

    // R11 chained sweep
    prev = -1;
    for (int c = 0; c < 256; c++) begin
      c_sel = 7'(c); c_top = c[7];
      step(3);
      chk("R11 chain sum", int'(d1) + int'(d2), c);
      if (int'(d1) + int'(d2) <= prev) chk("R11 monotonic", int'(d1) + int'(d2), prev + 1);
      prev = int'(d1) + int'(d2);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule